// File: doc/BRIEF.md
# Timer and Watchdog with Shared Scaler

This block combines an 8-bit timer/counter and a watchdog counter around a single 8-bit divider. A select input hands the divider to one side at a time. Given to the timer, it becomes a prescaler in front of the timer and divides its count events by 2 to 256. Given to the watchdog, it becomes a postscaler behind the watchdog's base period and stretches the time-out by 1 to 128. The side that does not own the divider runs undivided.

The timer counts either instruction cycles (one per clock) or edges on an external pin. The pin is passed through a synchronizer, and either its rising or its falling edge is selected. A register write loads the timer, restarts the divider when the timer owns it, and blocks counting for the two cycles that follow. When the timer rolls over from FFh to 00h, a one-cycle flag is raised. The watchdog counts periodic ticks from a slow oscillator, which is modelled here as an input strobe. When it times out, it issues a one-cycle reset request and clears a time-out status bit. A clear-watchdog strobe or a sleep strobe restarts the watchdog and sets the status bit again.

Top module: `tmr_wdt_scaler`

## Requirements
- R1: While reset is held, the timer value is 00h, the overflow flag and the reset request are low, and the time-out status is 1. The divider starts from all ones.
- R2: With the instruction clock as source (`cfg_pin_src`=0) and the divider given to the watchdog (`cfg_div_wdt`=1), the timer advances by one on every clock.
- R3: A timer write loads `tmr_wdata` on that edge and overrides any increment in the same cycle. No increment happens on the next two edges, and counting resumes on the third.
- R4: An increment from FFh to 00h raises `tmr_overflow` for exactly the one cycle after that edge. Loading a value never raises it.
- R5: With the divider given to the timer (`cfg_div_wdt`=0), ratio code r (0..7) gives one timer increment per 2^(r+1) count events. A timer write restarts the divider, so after the write edge the value is the written value plus floor((M-2)/2^(r+1)) after M edges.
- R6: With the pin as source (`cfg_pin_src`=1), the pin passes through a two-flop synchronizer. The timer counts only rising pin edges when `cfg_fall_edge`=0, and only falling pin edges when it is 1.
- R7: With the divider given to the timer, an enabled watchdog times out on every WDT_BASE-th tick. The time-out pulses `wdt_reset_req` for one cycle and clears `wdt_to_n`, which stays 0 until the next clear or sleep strobe.
- R8: With the divider given to the watchdog, ratio code r stretches the time-out to WDT_BASE*2^r ticks.
- R9: A clear-watchdog or sleep strobe restarts the watchdog count and sets `wdt_to_n` to 1. It also restarts the divider when the watchdog owns it. A tick in the same cycle as the strobe is dropped.
- R10: While `wdt_en` is 0, ticks have no effect and no reset request is raised.
- R11: A timer write does not disturb the divider while the watchdog owns it. A clear-watchdog strobe does not disturb the divider while the timer owns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div_wdt | input | 1 | Divider owner: 0 timer (prescale), 1 watchdog (postscale) |
| cfg_ratio | input | 3 | Divider ratio code |
| cfg_pin_src | input | 1 | Timer source: 0 instruction clock, 1 external pin |
| cfg_fall_edge | input | 1 | Pin edge: 0 rising, 1 falling |
| tmr_pin | input | 1 | External count pin, asynchronous |
| tmr_wr | input | 1 | Timer register write strobe |
| tmr_wdata | input | 8 | Timer write data |
| wdt_en | input | 1 | Watchdog enable |
| wdt_tick | input | 1 | Slow-oscillator tick strobe |
| wdt_clr | input | 1 | Clear-watchdog strobe |
| sleep_req | input | 1 | Sleep-entry strobe |
| tmr_value | output | 8 | Current timer value |
| tmr_overflow | output | 1 | One-cycle rollover pulse |
| wdt_reset_req | output | 1 | One-cycle watchdog time-out reset request |
| wdt_to_n | output | 1 | Time-out status, 0 after a time-out |

## Verification
Two collisions are forced. The first is a clear-watchdog strobe driven in the same cycle as the tick that would otherwise expire the watchdog. This is judged correct when no reset request appears, and when a full WDT_BASE ticks after the clear are then needed before the next time-out. The second is a timer write that lands on a cycle when an internal increment is due. This is judged from the timer value on the following edges: it must hold the written value, unchanged, for three samples. The divider's ownership is also checked across these events, by counting the ticks or cycles until the next watchdog time-out or timer step after a strobe aimed at the other side.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int TMR_W    = 8;
    localparam int DIV_W    = 8;
    localparam int RATIO_W  = 3;
    localparam int INHIBIT  = 2;
    localparam int INH_W    = $clog2(INHIBIT + 1);

    typedef enum logic {
        DIV_TO_TIMER = 1'b0,
        DIV_TO_WDT   = 1'b1
    } div_owner_e;

    typedef struct packed {
        logic restart;
        logic step;
    } div_ctl_t;

    // Low-bit mask of the divider: timer ratio 2^(r+1), watchdog 2^r
    function automatic logic [DIV_W-1:0] ratio_mask(input logic [RATIO_W-1:0] code,
                                                    input div_owner_e owner);
        logic [DIV_W:0] span;
        int sh;
        sh   = int'(code) + ((owner == DIV_TO_TIMER) ? 1 : 0);
        span = (DIV_W+1)'(1) << sh;
        return DIV_W'(span - (DIV_W+1)'(1));
    endfunction

endpackage

// File: rtl/tws_pin_edge.sv
module tws_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_evt
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q[0] <= pin;
            for (int i = 1; i < STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            last_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        if (fall_sel) edge_evt = last_q & ~sync_q[STAGES-1];
        else          edge_evt = ~last_q & sync_q[STAGES-1];
    end
endmodule

// File: rtl/tws_divider.sv
module tws_divider
    import tws_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  div_ctl_t         ctl,
    input  logic [DIV_W-1:0] mask,
    output logic             fire
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.restart) cnt_q <= '1;
        else if (ctl.step)      cnt_q <= cnt_q - DIV_W'(1);
    end

    // One output per 2^k input steps: fire when the masked bits are about to borrow
    assign fire = ctl.step && !ctl.restart && ((cnt_q & mask) == '0);
endmodule

// File: rtl/tws_wdt_base.sv
module tws_wdt_base #(
    parameter int BASE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic restart,
    output logic base_evt
);
    localparam int CW = (BASE > 1) ? $clog2(BASE) : 1;
    localparam logic [CW-1:0] LAST = CW'(BASE - 1);

    logic [CW-1:0] cnt_q;
    logic          step;

    assign step     = en && tick && !restart;
    assign base_evt = step && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)  cnt_q <= '0;
        else if (base_evt)   cnt_q <= '0;
        else if (step)       cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/tmr_wdt_scaler.sv
module tmr_wdt_scaler
    import tws_pkg::*;
#(
    parameter int WDT_BASE    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_div_wdt,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic               cfg_pin_src,
    input  logic               cfg_fall_edge,
    input  logic               tmr_pin,
    input  logic               tmr_wr,
    input  logic [TMR_W-1:0]   tmr_wdata,
    input  logic               wdt_en,
    input  logic               wdt_tick,
    input  logic               wdt_clr,
    input  logic               sleep_req,
    output logic [TMR_W-1:0]   tmr_value,
    output logic               tmr_overflow,
    output logic               wdt_reset_req,
    output logic               wdt_to_n
);
    localparam logic [TMR_W-1:0] TMR_TOP = '1;

    div_owner_e       owner;
    logic             pin_evt;
    logic [INH_W-1:0] inh_q;
    logic             raw_evt;
    logic             wdt_restart;
    logic             base_evt;
    div_ctl_t         div_ctl;
    logic [DIV_W-1:0] div_mask;
    logic             div_fire;
    logic             tmr_inc;
    logic             timeout;

    assign owner = div_owner_e'(cfg_div_wdt);

    tws_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
        .clk      (clk),
        .rst      (rst),
        .pin      (tmr_pin),
        .fall_sel (cfg_fall_edge),
        .edge_evt (pin_evt)
    );

    // Count events before the divider, gated by the post-write hold-off
    assign raw_evt = !tmr_wr && (inh_q == '0) && (cfg_pin_src ? pin_evt : 1'b1);

    always_ff @(posedge clk) begin
        if (rst)              inh_q <= '0;
        else if (tmr_wr)      inh_q <= INH_W'(INHIBIT);
        else if (inh_q != '0) inh_q <= inh_q - INH_W'(1);
    end

    assign wdt_restart = wdt_clr || sleep_req;

    tws_wdt_base #(.BASE(WDT_BASE)) u_wdt (
        .clk      (clk),
        .rst      (rst),
        .en       (wdt_en),
        .tick     (wdt_tick),
        .restart  (wdt_restart),
        .base_evt (base_evt)
    );

    always_comb begin
        div_mask = ratio_mask(cfg_ratio, owner);
        if (owner == DIV_TO_TIMER) begin
            div_ctl.step    = raw_evt;
            div_ctl.restart = tmr_wr;
        end else begin
            div_ctl.step    = base_evt;
            div_ctl.restart = wdt_restart;
        end
    end

    tws_divider u_div (
        .clk  (clk),
        .rst  (rst),
        .ctl  (div_ctl),
        .mask (div_mask),
        .fire (div_fire)
    );

    assign tmr_inc = (owner == DIV_TO_TIMER) ? div_fire : raw_evt;
    assign timeout = (owner == DIV_TO_WDT)   ? div_fire : base_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_value    <= '0;
            tmr_overflow <= 1'b0;
        end else if (tmr_wr) begin
            tmr_value    <= tmr_wdata;
            tmr_overflow <= 1'b0;
        end else begin
            tmr_overflow <= tmr_inc && (tmr_value == TMR_TOP);
            if (tmr_inc) tmr_value <= tmr_value + TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wdt_reset_req <= 1'b0;
            wdt_to_n      <= 1'b1;
        end else begin
            wdt_reset_req <= timeout;
            if (wdt_restart)  wdt_to_n <= 1'b1;
            else if (timeout) wdt_to_n <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_wdt_scaler_chk.sv
module tmr_wdt_scaler_chk
    import tws_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cfg_div_wdt,
    input logic [RATIO_W-1:0] cfg_ratio,
    input logic               cfg_pin_src,
    input logic               cfg_fall_edge,
    input logic               tmr_pin,
    input logic               tmr_wr,
    input logic [TMR_W-1:0]   tmr_wdata,
    input logic               wdt_en,
    input logic               wdt_tick,
    input logic               wdt_clr,
    input logic               sleep_req,
    input logic [TMR_W-1:0]   tmr_value,
    input logic               tmr_overflow,
    input logic               wdt_reset_req,
    input logic               wdt_to_n
);
    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (tmr_value == '0 && !tmr_overflow && !wdt_reset_req && wdt_to_n)); // R1

    AST_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
        (cfg_div_wdt && !cfg_pin_src && !tmr_wr && !$past(tmr_wr) && !$past(tmr_wr, 2))
        |=> tmr_value == TMR_W'($past(tmr_value) + TMR_W'(1))); // R2

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
        tmr_wr |=> tmr_value == $past(tmr_wdata)); // R3

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tmr_wr && $past(tmr_wr)) |=> $stable(tmr_value)); // R3

    AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        tmr_overflow |-> tmr_value == '0); // R4

    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tmr_overflow |=> !tmr_overflow); // R4

    AST_REQ_CLEARS_STATUS: assert property (@(posedge clk) disable iff (rst)
        wdt_reset_req |-> !wdt_to_n); // R7

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (wdt_clr || sleep_req) |=> (!wdt_reset_req && wdt_to_n)); // R9

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wdt_en |=> !wdt_reset_req); // R10
endmodule

bind tmr_wdt_scaler tmr_wdt_scaler_chk u_chk (.*);

// File: tb/tmr_wdt_scaler_bench.sv
module tmr_wdt_scaler_bench;
    localparam int BASE = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_div_wdt = 1'b1;
    logic [2:0] cfg_ratio = 3'd0;
    logic       cfg_pin_src = 1'b0;
    logic       cfg_fall_edge = 1'b0;
    logic       tmr_pin = 1'b0;
    logic       tmr_wr = 1'b0;
    logic [7:0] tmr_wdata = 8'h00;
    logic       wdt_en = 1'b0;
    logic       wdt_tick = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       sleep_req = 1'b0;
    logic [7:0] tmr_value;
    logic       tmr_overflow;
    logic       wdt_reset_req;
    logic       wdt_to_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    tmr_wdt_scaler #(.WDT_BASE(BASE), .SYNC_STAGES(2)) u_tmr_wdt_scaler (.*);

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_tmr(input logic [7:0] v);
        tmr_wdata = v;
        tmr_wr = 1'b1;
        @(negedge clk);
        tmr_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        wdt_clr = 1'b1;
        @(negedge clk);
        wdt_clr = 1'b0;
    endtask

    // Sends n ticks; returns the 1-based tick index of the first time-out, 0 if none
    task automatic run_ticks(input int n, output int first_hit);
        first_hit = 0;
        for (int i = 0; i < n; i++) begin
            wdt_tick = 1'b1;
            @(negedge clk);
            wdt_tick = 1'b0;
            if (wdt_reset_req && first_hit == 0) first_hit = i + 1;
        end
    endtask

    task automatic t_reset();
        cyc(1);
        check("R1 timer", tmr_value, 0);
        check("R1 overflow", tmr_overflow, 0);
        check("R1 reset request", wdt_reset_req, 0);
        check("R1 status", wdt_to_n, 1);
        rst = 1'b0;
    endtask

    task automatic t_free_run();
        cfg_div_wdt = 1'b1; cfg_pin_src = 1'b0;
        wr_tmr(8'h10);
        cyc(2);
        cyc(5);   // edges 3..7 after the write increment
        check("R2 free run", tmr_value, 8'h15);
    endtask

    task automatic t_write_holdoff();
        cfg_div_wdt = 1'b1; cfg_pin_src = 1'b0;
        wr_tmr(8'h40);
        check("R3 load overrides increment", tmr_value, 8'h40);
        cyc(1);
        check("R3 hold edge 1", tmr_value, 8'h40);
        cyc(1);
        check("R3 hold edge 2", tmr_value, 8'h40);
        cyc(1);
        check("R3 resume edge 3", tmr_value, 8'h41);
    endtask

    task automatic t_overflow();
        cfg_div_wdt = 1'b1; cfg_pin_src = 1'b0;
        wr_tmr(8'hFF);
        wr_tmr(8'h00);
        check("R4 load gives no overflow", tmr_overflow, 0);
        wr_tmr(8'hFD);
        cyc(4);
        check("R4 before wrap", tmr_overflow, 0);
        cyc(1);
        check("R4 wrap value", tmr_value, 0);
        check("R4 overflow pulse", tmr_overflow, 1);
        cyc(1);
        check("R4 pulse is one cycle", tmr_overflow, 0);
    endtask

    task automatic t_prescale();
        cfg_div_wdt = 1'b0; cfg_pin_src = 1'b0;
        cfg_ratio = 3'd0;
        wr_tmr(8'h20);
        cyc(10);
        check("R5 ratio 1:2", tmr_value, 8'h24);
        cfg_ratio = 3'd2;
        wr_tmr(8'h20);
        cyc(22);
        check("R5 ratio 1:8", tmr_value, 8'h22);
        cfg_ratio = 3'd7;
        wr_tmr(8'h80);
        cyc(257);
        check("R5 ratio 1:256 before step", tmr_value, 8'h80);
        cyc(1);
        check("R5 ratio 1:256 step", tmr_value, 8'h81);
    endtask

    task automatic t_pin_edges();
        cfg_div_wdt = 1'b1; cfg_pin_src = 1'b1; cfg_fall_edge = 1'b0;
        tmr_pin = 1'b0;
        cyc(6);
        wr_tmr(8'h00);
        cyc(4);
        // rising edges 3, falling 2
        tmr_pin = 1'b1; cyc(5); tmr_pin = 1'b0; cyc(5);
        tmr_pin = 1'b1; cyc(5); tmr_pin = 1'b0; cyc(5);
        tmr_pin = 1'b1; cyc(6);
        check("R6 rising edges", tmr_value, 3);
        cfg_fall_edge = 1'b1;
        wr_tmr(8'h00);
        cyc(4);
        // falling 3, rising 2
        tmr_pin = 1'b0; cyc(5); tmr_pin = 1'b1; cyc(5);
        tmr_pin = 1'b0; cyc(5); tmr_pin = 1'b1; cyc(5);
        tmr_pin = 1'b0; cyc(6);
        check("R6 falling edges", tmr_value, 3);
        cfg_pin_src = 1'b0; cfg_fall_edge = 1'b0;
    endtask

    task automatic t_wdt_base();
        int hit;
        cfg_div_wdt = 1'b0; wdt_en = 1'b1;
        pulse_clr();
        run_ticks(BASE - 1, hit);
        check("R7 no early time-out", hit, 0);
        run_ticks(1, hit);
        check("R7 time-out on last tick", hit, 1);
        check("R7 status cleared", wdt_to_n, 0);
        cyc(1);
        check("R7 request is one cycle", wdt_reset_req, 0);
        check("R7 status held", wdt_to_n, 0);
        pulse_clr();
        check("R9 clear sets status", wdt_to_n, 1);
    endtask

    task automatic t_wdt_post();
        int hit;
        cfg_div_wdt = 1'b1; cfg_ratio = 3'd2; wdt_en = 1'b1;
        pulse_clr();
        run_ticks(4 * BASE, hit);
        check("R8 postscale 1:4 tick index", hit, 4 * BASE);
    endtask

    task automatic t_wdt_collide();
        int hit;
        cfg_div_wdt = 1'b0; wdt_en = 1'b1;
        pulse_clr();
        run_ticks(BASE - 1, hit);
        wdt_tick = 1'b1; wdt_clr = 1'b1;
        @(negedge clk);
        wdt_tick = 1'b0; wdt_clr = 1'b0;
        check("R9 clear beats coincident tick", wdt_reset_req, 0);
        run_ticks(BASE, hit);
        check("R9 full period after clear", hit, BASE);
        // sleep restarts the postscaler when the watchdog owns it
        cfg_div_wdt = 1'b1; cfg_ratio = 3'd1;
        pulse_clr();
        run_ticks(BASE, hit);
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
        check("R9 sleep sets status", wdt_to_n, 1);
        run_ticks(2 * BASE, hit);
        check("R9 sleep restarts postscaler", hit, 2 * BASE);
    endtask

    task automatic t_wdt_disabled();
        int hit;
        cfg_div_wdt = 1'b0;
        pulse_clr();
        wdt_en = 1'b0;
        run_ticks(3 * BASE, hit);
        check("R10 disabled no time-out", hit, 0);
        check("R10 disabled status", wdt_to_n, 1);
    endtask

    task automatic t_ownership();
        int hit;
        // watchdog owns divider: timer write must not restart it
        cfg_div_wdt = 1'b1; cfg_ratio = 3'd1; wdt_en = 1'b1;
        pulse_clr();
        run_ticks(BASE, hit);
        wr_tmr(8'h33);
        run_ticks(BASE, hit);
        check("R11 timer write leaves postscaler", hit, BASE);
        // timer owns divider: watchdog clear must not restart it
        wdt_en = 1'b0;
        cfg_div_wdt = 1'b0; cfg_ratio = 3'd3;
        wr_tmr(8'h50);
        cyc(12);
        pulse_clr();
        cyc(9);
        check("R11 watchdog clear leaves prescaler", tmr_value, 8'h51);
    endtask

    initial begin
        #(200000 * 8);
        n_fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        cyc(3);
        t_reset();
        t_free_run();
        t_write_holdoff();
        t_overflow();
        t_prescale();
        t_pin_edges();
        t_wdt_base();
        t_wdt_post();
        t_wdt_collide();
        t_wdt_disabled();
        t_ownership();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule